// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A 32-pin general-purpose I/O bank, split into four 8-bit ports and reached over a simple byte-addressed register bus with per-lane write strobes. Each pin has a direction bit and an output bit. Pin levels are read back through a two-flop synchronizer. Each pin also has a two-bit field that both selects which edges it watches and turns its interrupt on or off.

A watched edge on a synchronized pin sets a per-pin pending bit. Software clears a pending bit by writing 1 to it. Every pending bit whose pin has a nonzero edge field drives one shared interrupt line to a parent controller. The register map uses 32-bit words. Port A sits in byte lane 0 of each one-bit-per-pin word, then B, C and D in lanes 1 to 3. The edge fields need two bits per pin, so one 16-bit halfword covers a port.

The block has no sequencing state machine. Its only state is held in plain registers: direction, output, edge fields, synchronizer stages, edge history and pending bits. Each of these updates on every clock.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the pin output, output enable and interrupt outputs are all 0. Direction, data (with pins low), pending and edge-field reads all return 0.
- R2: The direction word is at offset 0x08. Bit n set to 1 makes pin n an output (pin_oe[n]=1), and 0 makes it an input. Writes update only the byte lanes whose strobe is set.
- R3: The data word is at offset 0x0C. A write sets the output register for the strobed lanes only, and pin_out carries that register after the write edge.
- R4: A read of 0x0C returns the output register bit for output pins and the synchronized level for input pins. A pin change becomes visible after exactly two clock edges.
- R5: Edge fields are at 0x14 (port A in bits 15:0, port B in 31:16) and 0x18 (port C, then D). Pin p of a port uses bits [2p+1:2p] of its halfword. Fields read back as written, strobe by strobe.
- R6: Field code 0 watches nothing, 1 watches falling edges, 2 watches rising edges and 3 watches both. A watched edge sets the pending bit on the third clock edge after the pin changes. A pending bit stays set through further edges.
- R7: Pending bits are at 0x10, one bit per pin in port-lane order. Writing 1 to a bit in a strobed lane clears it. Writing 0, or writing 1 in an unstrobed lane, leaves it unchanged.
- R8: When a clear and a new watched edge for the same pin land on the same clock edge, the pending bit ends up set.
- R9: irq is 1 exactly when some pin has its pending bit set and a nonzero field. Setting a field to 0 hides that pin's pending bit from irq without clearing it.
- R10: Offsets 0x00, 0x04 and 0x1C read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wen | input | 1 | Write enable |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Pad output levels |
| pin_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the write clock edge. The bench reads back on the following falling edge, because bus_rdata is combinational from the address. A pin change needs two edges to appear in the data read. A pending bit and irq change at the third edge, so the bench counts exactly those edges before it samples. It also samples once at one edge short of the data latency, to confirm the old value is still there. The same-edge collision case drives the clear write two edges after the pin change, so both events reach the pending register on the same edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // 32-bit word indices inside the register window (byte offset / 4)
    localparam int DIR_WORD  = 2;
    localparam int DATA_WORD = 3;
    localparam int STAT_WORD = 4;
    localparam int TYPE_WORD = 5;

    // Per-pin edge field: which edges raise a pending bit
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

    // Edge counter since reset, so the two-deep history is valid
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    p_two_stage_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (sync_q == $past(d, 2)));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl,
    input  logic [2*W-1:0] type_cfg,
    input  logic [W-1:0]   clr,
    output logic [W-1:0]   status,
    output logic           pend
);
    logic [W-1:0] prev_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;
    logic [W-1:0] hit;
    logic [W-1:0] armed;

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        hit   = '0;
        armed = '0;
        for (int i = 0; i < W; i++) begin
            unique case (edge_sel_e'(type_cfg[2*i +: 2]))
                EDGE_OFF:  begin hit[i] = 1'b0;              armed[i] = 1'b0; end
                EDGE_FALL: begin hit[i] = fall[i];           armed[i] = 1'b1; end
                EDGE_RISE: begin hit[i] = rise[i];           armed[i] = 1'b1; end
                EDGE_BOTH: begin hit[i] = rise[i] | fall[i]; armed[i] = 1'b1; end
            endcase
        end
    end

    // A new edge outranks a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~clr) | hit;
        end
    end

    assign status = stat_q;
    assign pend   = |(stat_q & armed);

    p_edge_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~hit) != '0) |=> ((stat_q & $past(clr & ~hit)) == '0));

    p_edge_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & hit) != '0) |=> ((stat_q & $past(clr & hit)) == $past(clr & hit)));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wen,
    input  logic [(PORT_W*NUM_PORTS)/8-1:0] bus_wstrb,
    input  logic [PORT_W*NUM_PORTS-1:0]   bus_wdata,
    output logic [PORT_W*NUM_PORTS-1:0]   bus_rdata,
    input  logic [PORT_W*NUM_PORTS-1:0]   pin_in,
    output logic [PORT_W*NUM_PORTS-1:0]   pin_out,
    output logic [PORT_W*NUM_PORTS-1:0]   pin_oe,
    output logic                          irq
);
    localparam int PINS   = PORT_W * NUM_PORTS;
    localparam int LANES  = PINS / 8;
    localparam int TW     = 2 * PORT_W;
    localparam int PER_TW = PINS / TW;
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              unused_lsb;
    logic [PINS-1:0]   wmask;
    logic [PINS-1:0]   pin_lvl;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   out_q;
    logic [PINS-1:0]   stat_clr;
    logic [PINS-1:0]   stat_all;
    logic [NUM_PORTS-1:0]         pend_all;
    logic [NUM_PORTS-1:0][TW-1:0] type_q;

    assign word       = bus_addr[ADDR_W-1:2];
    assign unused_lsb = ^bus_addr[1:0];

    always_comb begin
        for (int l = 0; l < LANES; l++) wmask[8*l +: 8] = {8{bus_wstrb[l]}};
    end

    gpio_pin_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (bus_wen) begin
            if (word == WORD_W'(DIR_WORD))  dir_q <= (dir_q & ~wmask) | (bus_wdata & wmask);
            if (word == WORD_W'(DATA_WORD)) out_q <= (out_q & ~wmask) | (bus_wdata & wmask);
        end
    end

    assign stat_clr = (bus_wen && word == WORD_W'(STAT_WORD)) ? (bus_wdata & wmask) : '0;

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        localparam int TWORD = TYPE_WORD + k / PER_TW;
        localparam int TOFS  = TW * (k % PER_TW);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) type_q[k] <= '0;
            else if (bus_wen && word == WORD_W'(TWORD))
                type_q[k] <= (type_q[k] & ~wmask[TOFS +: TW]) | (bus_wdata[TOFS +: TW] & wmask[TOFS +: TW]);
        end

        gpio_edge_port #(.W(PORT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl      (pin_lvl[PORT_W*k +: PORT_W]),
            .type_cfg (type_q[k]),
            .clr      (stat_clr[PORT_W*k +: PORT_W]),
            .status   (stat_all[PORT_W*k +: PORT_W]),
            .pend     (pend_all[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (word == WORD_W'(DIR_WORD))  bus_rdata = dir_q;
        if (word == WORD_W'(DATA_WORD)) bus_rdata = (dir_q & out_q) | (~dir_q & pin_lvl);
        if (word == WORD_W'(STAT_WORD)) bus_rdata = stat_all;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (word == WORD_W'(TYPE_WORD + k / PER_TW))
                bus_rdata[TW*(k % PER_TW) +: TW] = type_q[k];
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |pend_all;

    p_oe_tracks_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && word == WORD_W'(DIR_WORD) && (&bus_wstrb)) |=> (pin_oe == $past(bus_wdata)));

    p_out_tracks_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && word == WORD_W'(DATA_WORD) && (&bus_wstrb)) |=> (pin_out == $past(bus_wdata)));

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_all != '0));
endmodule

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_bank u_gpio_edge_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wstrb (bus_wstrb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_wen = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wen = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] lane_mask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    initial begin : watchdog
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] exp_dir;
        logic [31:0] exp_out;
        logic [31:0] wd;
        logic [31:0] pins;

        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        rd(5'h08, v); check("R1 dir", v, 32'h0);
        rd(5'h0C, v); check("R1 data", v, 32'h0);
        rd(5'h10, v); check("R1 status", v, 32'h0);
        rd(5'h14, v); check("R1 type AB", v, 32'h0);
        rd(5'h18, v); check("R1 type CD", v, 32'h0);

        // R10 unmapped words
        wr(5'h00, 32'hFFFF_FFFF, 4'hF);
        wr(5'h04, 32'hFFFF_FFFF, 4'hF);
        wr(5'h1C, 32'hFFFF_FFFF, 4'hF);
        rd(5'h00, v); check("R10 offset 00", v, 32'h0);
        rd(5'h04, v); check("R10 offset 04", v, 32'h0);
        rd(5'h1C, v); check("R10 offset 1C", v, 32'h0);
        check("R10 oe untouched", pin_oe, 32'h0);
        check("R10 out untouched", pin_out, 32'h0);

        // R2 / R3 strobe sweep
        exp_dir = '0;
        exp_out = '0;
        for (int s = 0; s < 16; s++) begin
            wd = {4{8'(s * 17 + 3)}} ^ 32'hC3A5_5A3C;
            wr(5'h08, wd, 4'(s));
            exp_dir = (exp_dir & ~lane_mask(4'(s))) | (wd & lane_mask(4'(s)));
            check("R2 pin_oe", pin_oe, exp_dir);
            rd(5'h08, v); check("R2 dir readback", v, exp_dir);
            wr(5'h0C, ~wd, 4'(15 - s));
            exp_out = (exp_out & ~lane_mask(4'(15 - s))) | (~wd & lane_mask(4'(15 - s)));
            check("R3 pin_out", pin_out, exp_out);
        end

        // R4 data read mix and latency
        wr(5'h08, 32'h0F0F_00FF, 4'hF);
        wr(5'h0C, 32'hAAAA_5555, 4'hF);
        pins = 32'h3C5A_9617;
        pin_in = pins;
        edges(1);
        rd(5'h0C, v);
        check("R4 one edge: old level", v, 32'h0F0F_00FF & 32'hAAAA_5555);
        edges(1);
        rd(5'h0C, v);
        check("R4 two edges: mixed", v, (32'h0F0F_00FF & 32'hAAAA_5555) | (~32'h0F0F_00FF & pins));

        // back to all inputs, pins low, status clean
        wr(5'h08, 32'h0, 4'hF);
        pin_in = '0;
        edges(4);
        wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        rd(5'h10, v); check("R6 status clean (no fields)", v, 32'h0);

        // R5 field readback by strobe
        wr(5'h14, 32'h1234_ABCD, 4'b0101);
        rd(5'h14, v); check("R5 type AB strobes", v, 32'h0034_00CD);
        wr(5'h18, 32'h8765_4321, 4'b1010);
        rd(5'h18, v); check("R5 type CD strobes", v, 32'h8700_4300);
        wr(5'h14, 32'h0, 4'hF);
        wr(5'h18, 32'h0, 4'hF);

        // R5 / R6 / R9 sweep: every pin, every code
        for (int p = 0; p < 32; p++) begin
            for (int c = 0; c < 4; c++) begin
                logic [31:0] f;
                logic [31:0] bit_p;
                bit_p = 32'h1 << p;
                f = 32'(c) << (16 * ((p / 8) % 2) + 2 * (p % 8));
                wr(5'h14, (p < 16) ? f : 32'h0, 4'hF);
                wr(5'h18, (p < 16) ? 32'h0 : f, 4'hF);
                pin_in[p] = 1'b1;
                edges(3);
                rd(5'h10, v);
                check("R6 rise sets per code", v, c[1] ? bit_p : 32'h0);
                check("R9 irq after rise", {31'h0, irq}, {31'h0, c[1]});
                wr(5'h10, bit_p, 4'hF);
                pin_in[p] = 1'b0;
                edges(3);
                rd(5'h10, v);
                check("R6 fall sets per code", v, c[0] ? bit_p : 32'h0);
                check("R9 irq after fall", {31'h0, irq}, {31'h0, c[0]});
                wr(5'h10, bit_p, 4'hF);
            end
        end
        wr(5'h18, 32'h0, 4'hF);

        // R6 sticky, R9 masking, R7 clear rules on pin 13 (port B pin 5)
        wr(5'h14, 32'h3 << 26, 4'hF);
        pin_in[13] = 1'b1;
        edges(3);
        pin_in[13] = 1'b0;
        edges(3);
        rd(5'h10, v); check("R6 stays set over second edge", v, 32'h0000_2000);
        wr(5'h14, 32'h0, 4'hF);
        check("R9 field 0 hides irq", {31'h0, irq}, 32'h0);
        rd(5'h10, v); check("R9 pending kept while hidden", v, 32'h0000_2000);
        wr(5'h14, 32'h3 << 26, 4'hF);
        check("R9 irq returns", {31'h0, irq}, 32'h1);
        wr(5'h10, 32'h0, 4'hF);
        rd(5'h10, v); check("R7 write 0 no effect", v, 32'h0000_2000);
        wr(5'h10, 32'h0000_2000, 4'b1101);
        rd(5'h10, v); check("R7 unstrobed lane no effect", v, 32'h0000_2000);
        wr(5'h10, 32'hFFFF_DFFF, 4'hF);
        rd(5'h10, v); check("R7 other bits no effect", v, 32'h0000_2000);
        wr(5'h10, 32'h0000_2000, 4'b0010);
        rd(5'h10, v); check("R7 write 1 clears", v, 32'h0);
        check("R9 irq low after clear", {31'h0, irq}, 32'h0);

        // R8 clear and edge on the same clock edge
        pin_in[13] = 1'b1;
        edges(3);
        rd(5'h10, v); check("R8 setup pending", v, 32'h0000_2000);
        pin_in[13] = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr(5'h10, 32'h0000_2000, 4'hF);
        rd(5'h10, v); check("R8 edge wins over clear", v, 32'h0000_2000);
        check("R8 irq still high", {31'h0, irq}, 32'h1);
        wr(5'h10, 32'h0000_2000, 4'hF);
        rd(5'h10, v); check("R8 plain clear afterwards", v, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule